// File: doc/BRIEF.md
# Halt and Wake Sequencer

This block sits beside a small microcontroller core and manages its power-down (halt) state. A one-cycle halt strobe from the instruction decoder parks the block in the halted state. The core is stalled there. While halted, the block watches four wake sources: an external reset request, a fresh interrupt request, a falling edge on an enabled pin of an input port, and a watchdog overflow.

When a wake source fires, the block records how the core must resume. It then holds the stall for a fixed settling window. At the end of that window it releases the core with a one-cycle resume pulse and a resume code. The code selects one of four paths: continue at the next instruction, take the interrupt vector, apply a warm reset (program counter and stack pointer only), or apply a full device reset. Interrupts already pending when halt was entered are masked as wake sources for the whole stay in halt.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset the block is in the run state: `stall_o`, `halted_o`, `resume_o`, `warm_rst_o` and `full_rst_o` are all 0.
- R2: A `halt_i` pulse in the run state sets `halted_o` and `stall_o` from the next cycle onward. `stall_o` stays 1 until the cycle in which `resume_o` pulses.
- R3: An external reset request (`ext_rst_i`) in halt ends with resume code 3 (full reset). `full_rst_o` pulses together with `resume_o`.
- R4: A watchdog overflow (`wdt_ovf_i`) in halt ends with resume code 2 (warm reset). `warm_rst_o` pulses together with `resume_o`, and `full_rst_o` stays 0.
- R5: In halt, a falling edge on a pin whose bit in `pin_wake_en_i` is 1 wakes the block with resume code 0 (next instruction). The wake takes effect on the third clock edge after the pin changes, because of the two-stage synchroniser and the edge register.
- R6: In halt, falling edges on disabled pins and rising edges on enabled pins cause no wake.
- R7: In halt, a new interrupt request wakes the block with resume code 1 (vector) if that request's enable bit is 1 and `stack_full_i` is 0 in the wake cycle.
- R8: An interrupt wake with the enable bit clear, or with `stack_full_i` at 1, gives resume code 0.
- R9: Request bits already set on the cycle that halt is entered cannot wake the block during that halt.
- R10: From the clock edge that accepts a wake to the clock edge that raises `resume_o`, exactly SETTLE_CYCLES (1024 by default) edges pass. `resume_o` is a single-cycle pulse.
- R11: When several wake sources fire in the same cycle, the priority is external reset, then watchdog, then interrupt, then pin.
- R12: In the run state, wake inputs cause no resume pulse and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt instruction strobe |
| ext_rst_i | input | 1 | External reset request (synchronous) |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| irq_req_i | input | IRQ_W | Interrupt request flags |
| irq_en_i | input | IRQ_W | Per-request interrupt enables |
| stack_full_i | input | 1 | Return stack is full |
| pin_i | input | PORT_W | Asynchronous port pins |
| pin_wake_en_i | input | PORT_W | Per-pin wake enable |
| stall_o | output | 1 | Core stall |
| halted_o | output | 1 | Block is in the halted state |
| resume_o | output | 1 | One-cycle release pulse |
| resume_kind_o | output | 2 | 0 next instr, 1 vector, 2 warm reset, 3 full reset |
| warm_rst_o | output | 1 | Warm reset pulse |
| full_rst_o | output | 1 | Full reset pulse |

## Verification
The assertions check on every cycle that a halt strobe leads to a stall and that an external reset or a watchdog overflow in halt selects the right resume code. They also check that the halt state holds when only masked requests are present, that the settle counter moves one step per cycle, and that the release pulse lasts a single cycle. The bench scenarios cover what only end-to-end timing can show. These are the exact wake-to-release latency for each source, the extra synchroniser delay on pins, and the rejection of disabled pins and rising edges. They also cover the priority results when strobes coincide and the pending-at-entry mask across a whole halt.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } hw_state_e;

  typedef enum logic [1:0] {
    RES_NEXT   = 2'd0,
    RES_VECTOR = 2'd1,
    RES_WARM   = 2'd2,
    RES_FULL   = 2'd3
  } resume_kind_e;
endpackage

// File: rtl/pin_fall_detect.sv
module pin_fall_detect #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  // reset to idle-high so no edge is seen after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall_o = prev_q & ~s2_q;
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter
  import halt_wake_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             ext_rst_i,
  input  logic             wdt_ovf_i,
  input  logic [IRQ_W-1:0] irq_req_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic [IRQ_W-1:0] pend_mask_i,
  input  logic             stack_full_i,
  input  logic             pin_wake_i,
  output logic             wake_o,
  output resume_kind_e     kind_o
);
  logic [IRQ_W-1:0] fresh;
  assign fresh = irq_req_i & ~pend_mask_i;

  always_comb begin
    wake_o = 1'b1;
    kind_o = RES_NEXT;
    if (ext_rst_i)       kind_o = RES_FULL;
    else if (wdt_ovf_i)  kind_o = RES_WARM;
    else if (|fresh)     kind_o = ((|(fresh & irq_en_i)) && !stack_full_i) ? RES_VECTOR : RES_NEXT;
    else if (pin_wake_i) kind_o = RES_NEXT;
    else                 wake_o = 1'b0;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  p_count_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int IRQ_W         = 4,
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              ext_rst_i,
  input  logic              wdt_ovf_i,
  input  logic [IRQ_W-1:0]  irq_req_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  input  logic              stack_full_i,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] pin_wake_en_i,
  output logic              stall_o,
  output logic              halted_o,
  output logic              resume_o,
  output logic [1:0]        resume_kind_o,
  output logic              warm_rst_o,
  output logic              full_rst_o
);
  hw_state_e        state_q;
  resume_kind_e     kind_q, kind_d;
  logic [IRQ_W-1:0] pend_q;
  logic [PORT_W-1:0] pin_fall;
  logic             pin_wake, wake, settle_done, resume_q;

  pin_fall_detect #(.W(PORT_W)) u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .fall_o (pin_fall)
  );

  assign pin_wake = |(pin_fall & pin_wake_en_i);

  wake_arbiter #(.IRQ_W(IRQ_W)) u_arb (
    .ext_rst_i    (ext_rst_i),
    .wdt_ovf_i    (wdt_ovf_i),
    .irq_req_i    (irq_req_i),
    .irq_en_i     (irq_en_i),
    .pend_mask_i  (pend_q),
    .stack_full_i (stack_full_i),
    .pin_wake_i   (pin_wake),
    .wake_o       (wake),
    .kind_o       (kind_d)
  );

  settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SETTLE),
    .done_o (settle_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      kind_q   <= RES_NEXT;
      pend_q   <= '0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= settle_done;
      unique case (state_q)
        ST_RUN: if (halt_i) begin
          state_q <= ST_HALT;
          pend_q  <= irq_req_i;   // requests already up cannot wake
        end
        ST_HALT: if (wake) begin
          state_q <= ST_SETTLE;
          kind_q  <= kind_d;
        end
        ST_SETTLE: if (settle_done) state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign stall_o       = (state_q != ST_RUN);
  assign halted_o      = (state_q == ST_HALT);
  assign resume_o      = resume_q;
  assign resume_kind_o = kind_q;
  assign warm_rst_o    = resume_q && (kind_q == RES_WARM);
  assign full_rst_o    = resume_q && (kind_q == RES_FULL);

  p_halt_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && halt_i) |=> (stall_o && halted_o));

  p_ext_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && ext_rst_i) |=> (state_q == ST_SETTLE && resume_kind_o == 2'd3));

  p_wdt_warm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && wdt_ovf_i && !ext_rst_i) |=> (resume_kind_o == 2'd2));

  p_masked_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !ext_rst_i && !wdt_ovf_i && !pin_wake && ((irq_req_i & ~pend_q) == '0))
      |=> halted_o);

  p_resume_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> (!resume_o && !stall_o));
endmodule

// File: tb/tb_halt_wake_ctrl.sv
module tb_halt_wake_ctrl;
  localparam int N = 1024;
  localparam int PW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 0, ext = 0, wdt = 0, sfull = 0;
  logic [IW-1:0] irq = '0, irq_en = '0;
  logic [PW-1:0] pin = '1, pin_en = '0;
  logic stall, halted, resume, warm, full;
  logic [1:0] kind;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  halt_wake_ctrl #(.PORT_W(PW), .IRQ_W(IW), .SETTLE_CYCLES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .ext_rst_i(ext), .wdt_ovf_i(wdt),
    .irq_req_i(irq), .irq_en_i(irq_en), .stack_full_i(sfull), .pin_i(pin),
    .pin_wake_en_i(pin_en), .stall_o(stall), .halted_o(halted), .resume_o(resume),
    .resume_kind_o(kind), .warm_rst_o(warm), .full_rst_o(full)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic enter_halt();
    @(negedge clk); halt = 1;
    @(posedge clk); @(negedge clk); halt = 0;
    check(stall && halted, "R2 halt entry", {stall, halted}, 3);
  endtask

  // inputs are driven at a negedge just before calling; counts edges to resume
  task automatic wait_resume(input int exp_n, input int exp_kind, input string tag);
    int n = 0;
    bit stall_ok = 1;
    while (n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk);
      ext = 0; wdt = 0;
      if (resume) break;
      if (!stall) stall_ok = 0;
    end
    check(n == exp_n, {tag, " R10 latency"}, n, exp_n);
    check(stall_ok && !stall, {tag, " R2 stall held"}, stall, 0);
    check(kind == exp_kind[1:0], {tag, " code"}, kind, exp_kind);
    check(warm == (exp_kind == 2) && full == (exp_kind == 3), {tag, " rst pulses"},
          {warm, full}, (exp_kind == 2) ? 2 : (exp_kind == 3) ? 1 : 0);
    @(posedge clk); @(negedge clk);
    check(!resume, {tag, " R10 single pulse"}, resume, 0);
  endtask

  task automatic stay_halted(input int cycles, input string tag);
    bit ok = 1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      if (!halted || resume) ok = 0;
    end
    check(ok, tag, halted, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({stall, halted, resume, warm, full} == 5'b0, "R1 reset state",
          {stall, halted, resume, warm, full}, 0);
  endtask

  task automatic t_run_ignore();
    bit ok = 1;
    @(negedge clk); ext = 1; wdt = 1; irq = 4'b0001; pin_en = '1; pin = 8'h00;
    @(posedge clk); @(negedge clk); ext = 0; wdt = 0; irq = '0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (stall || resume) ok = 0;
    end
    pin = '1;
    repeat (4) @(negedge clk);
    check(ok, "R12 run ignores wake inputs", {stall, resume}, 0);
  endtask

  task automatic t_pin_wake();
    pin_en = 8'h10;
    enter_halt();
    pin[4] = 0;
    wait_resume(N + 3, 0, "R5 pin wake");
    pin = '1; pin_en = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_pin_ignore();
    pin_en = 8'h01; pin = 8'hFE;   // enabled pin low before halt
    repeat (4) @(negedge clk);
    enter_halt();
    pin = 8'h01;                   // enabled rises, disabled ones fall
    stay_halted(20, "R6 disabled fall / enabled rise ignored");
    wdt = 1;
    wait_resume(N + 1, 2, "R4 wdt after ignore");
    pin = '1; pin_en = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ext();
    enter_halt();
    ext = 1;
    wait_resume(N + 1, 3, "R3 ext reset");
  endtask

  task automatic t_irq(input logic [IW-1:0] en, input logic sf, input int exp, input string tag);
    irq_en = en; sfull = sf;
    enter_halt();
    irq = 4'b0100;
    wait_resume(N + 1, exp, tag);
    irq = '0; irq_en = '0; sfull = 0;
  endtask

  task automatic t_pending();
    irq_en = '1;
    @(negedge clk); irq = 4'b0010;
    enter_halt();
    stay_halted(30, "R9 pending request masked");
    irq = 4'b1010;
    wait_resume(N + 1, 1, "R9 fresh request wakes");
    irq = '0; irq_en = '0;
  endtask

  task automatic t_prio();
    irq_en = '1;
    enter_halt();
    ext = 1; wdt = 1; irq = 4'b0001;
    wait_resume(N + 1, 3, "R11 ext over wdt/irq");
    irq = '0;
    enter_halt();
    wdt = 1; irq = 4'b0001;
    wait_resume(N + 1, 2, "R11 wdt over irq");
    irq = '0; irq_en = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    t_run_ignore();
    t_pin_wake();
    t_pin_ignore();
    t_ext();
    t_irq(4'b0100, 1'b0, 1, "R7 irq vector");
    t_irq(4'b0000, 1'b0, 0, "R8 irq disabled");
    t_irq(4'b0100, 1'b1, 0, "R8 stack full");
    t_pending();
    t_prio();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule